// File: doc/BRIEF.md
# Serial Audio Frame-Boundary Shutdown Controller

This block makes the bit clock and frame sync for a serial audio transmitter or receiver of the I2S kind. It also tells the data shifter which frames carry real data. The bit clock comes from dividing the system clock. A frame is `FRAME_LEN` bit clocks long. Frame sync is high for either the first bit of the frame or the first `WORD_LEN` bits.

Turning the block off always happens at a frame boundary. When the enable drops, the frame in progress still completes. What happens next depends on a stop request. If the stop request was raised at any time since the last enable, the bit clock and frame sync stop driving at the end of that frame, and a done flag is raised. Without a stop request, the clocks keep running and the data-valid strobe stays low. A stop raised later ends the clocks at the next frame end.

The enable is committed four bit clocks before each boundary. If the enable drops inside the last four bits of a frame, the next frame has already been committed. That frame still runs, with data-valid held low, and the shutdown comes after it.

Top module: `audio_frame_clk_ctrl`

## Requirements
- R1: After reset, all outputs are low. This covers bit clock, frame sync, both drive enables, data-valid and done.
- R2: A rise of `en_i` starts a frame at bit 0.
  - A bit lasts `2*HALF_PER` system clocks, and the bit clock falls at each bit boundary.
  - A frame has `FRAME_LEN` bits.
  - `fs_o` is high for bit 0 only when `sync_wide_i`=0, and for bits 0 to `WORD_LEN-1` when `sync_wide_i`=1.
- R3: `data_valid_o` changes only at frame boundaries. It is high for every frame that was committed with `en_i` high and during which `en_i` stayed high.
- R4: If `en_i` drops before the commit point while a stop request is pending, the current frame completes. At its end, bit clock, frame sync, both drive enables and data-valid all go low.
- R5: `stop_clk_i` is held in a sticky register. A one-cycle pulse in an earlier frame still stops the block at the first frame end after the enable is committed low. The register clears on a rise of `en_i`. A stop pulse in the same cycle as that rise wins.
- R6: If `en_i` drops with no stop request pending, bit clock and frame sync keep running and `data_valid_o` is low from the next frame on.
- R7: A stop request raised while `en_i` is already low stops the block at the end of the frame in progress.
- R8: The commit point is the bit boundary where the bit index becomes `FRAME_LEN-4`. If `en_i` is first low after that point, one extra frame runs with `data_valid_o` low, and the block stops at its end.
- R9: `frame_done_o` is set in the cycle the block stops. It is cleared by a pulse on `done_clr_i` (a set in the same cycle wins). Otherwise it holds, and it is not set again until the block is re-enabled and stopped.
- R10: `bclk_oe_o` is high only while running with `clk_dir_out_i`=1. `fs_oe_o` is high only while running with `fs_dir_out_i`=1.
- R11: Re-enabling after a stop restarts at bit 0 with data valid. It also clears the stop request, so a later disable without a new stop request keeps the clocks running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer enable |
| stop_clk_i | input | 1 | Request to stop clock and sync at a frame end |
| sync_wide_i | input | 1 | 1: sync spans a word; 0: sync spans one bit |
| clk_dir_out_i | input | 1 | Bit clock is driven by this block |
| fs_dir_out_i | input | 1 | Frame sync is driven by this block |
| done_clr_i | input | 1 | Write-one-to-clear pulse for the done flag |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| bclk_oe_o | output | 1 | Bit clock pin drive enable |
| fs_oe_o | output | 1 | Frame sync pin drive enable |
| data_valid_o | output | 1 | Current frame carries shifter data |
| frame_done_o | output | 1 | Orderly stop completed |

## Verification
The bench first sweeps the bit at which the enable drops over every position of an 8-bit frame, in both sync widths. It then measures frames, sync-high time, valid time and drive time. These measurements separate an early disable (one frame) from a late disable inside the last four bits (one extra invalid frame). They also catch an off-by-one in the commit point.

Three more scenarios cover the other stop paths:
- A disable with no stop request, followed by a stop later in a frame, checks that the clocks keep running and then stop at the next boundary.
- A stop pulse given several frames before the disable checks that the request is sticky.
- A re-enable after a stop checks that the request was cleared and that done clears and holds.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } afc_state_e;
endpackage

// File: rtl/afc_bclk_div.sv
module afc_bclk_div #(
  parameter int HALF_PER = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bclk_o,
  output logic fall_o
);
  localparam int DW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_PER - 1);

  logic [DW-1:0] div_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = run_i & wrap & bclk_q;

  AST_BCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !bclk_q); // R4
endmodule

// File: rtl/afc_frame_cnt.sv
module afc_frame_cnt #(
  parameter int FRAME_LEN = 32,
  parameter int WORD_LEN  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic sync_wide_i,
  output logic frame_end_o,
  output logic commit_pt_o,
  output logic fs_o
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] CNT_LAST   = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] CNT_COMMIT = CW'(FRAME_LEN - 5);
  localparam logic [CW:0]   SYNC_BITS  = (CW+1)'(WORD_LEN);

  logic [CW-1:0] cnt_q;
  logic          last_bit;
  logic          sync_on;

  assign last_bit = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
  end

  assign frame_end_o = tick_i & last_bit;
  // enable is committed as the index enters the last four bits
  assign commit_pt_o = tick_i & (cnt_q == CNT_COMMIT);
  assign sync_on     = sync_wide_i ? ({1'b0, cnt_q} < SYNC_BITS) : (cnt_q == '0);
  assign fs_o        = run_i & sync_on;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R2
  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/afc_shutdown_fsm.sv
module afc_shutdown_fsm
  import afc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_req_i,
  input  logic done_clr_i,
  input  logic frame_end_i,
  input  logic commit_pt_i,
  output logic run_o,
  output logic valid_o,
  output logic done_o
);
  afc_state_e state_q;
  logic en_q, sticky_q, commit_q, valid_q, done_q;
  logic en_rise, stop_now;

  assign en_rise  = en_i & ~en_q;
  assign run_o    = (state_q == ST_RUN);
  assign stop_now = run_o & frame_end_i & ~commit_q & (sticky_q | stop_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      en_q     <= 1'b0;
      sticky_q <= 1'b0;
      commit_q <= 1'b0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      en_q     <= en_i;
      sticky_q <= (sticky_q & ~en_rise) | stop_req_i;
      if (stop_now)        done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (en_i) begin
            state_q  <= ST_RUN;
            commit_q <= 1'b1;
            valid_q  <= 1'b1;
          end
        end
        ST_RUN: begin
          if (commit_pt_i) commit_q <= en_i;
          if (stop_now) begin
            state_q  <= ST_IDLE;
            commit_q <= 1'b0;
            valid_q  <= 1'b0;
          end else if (frame_end_i) begin
            valid_q  <= commit_q & en_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = run_o & valid_q;
  assign done_o  = done_q;

  AST_STOP_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(frame_end_i)); // R4
  AST_VALID_FRAME_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o) && !$past(frame_end_i)) |-> $stable(valid_o)); // R3
  AST_COMMITTED_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && frame_end_i && commit_q) |=> run_o); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_clr_i) |=> done_q); // R9
endmodule

// File: rtl/audio_frame_clk_ctrl.sv
module audio_frame_clk_ctrl #(
  parameter int FRAME_LEN = 32,
  parameter int WORD_LEN  = 16,
  parameter int HALF_PER  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_clk_i,
  input  logic sync_wide_i,
  input  logic clk_dir_out_i,
  input  logic fs_dir_out_i,
  input  logic done_clr_i,
  output logic bclk_o,
  output logic fs_o,
  output logic bclk_oe_o,
  output logic fs_oe_o,
  output logic data_valid_o,
  output logic frame_done_o
);
  logic run, tick, frame_end, commit_pt;

  afc_bclk_div #(.HALF_PER(HALF_PER)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .bclk_o (bclk_o),
    .fall_o (tick)
  );

  afc_frame_cnt #(.FRAME_LEN(FRAME_LEN), .WORD_LEN(WORD_LEN)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (tick),
    .sync_wide_i (sync_wide_i),
    .frame_end_o (frame_end),
    .commit_pt_o (commit_pt),
    .fs_o        (fs_o)
  );

  afc_shutdown_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .stop_req_i  (stop_clk_i),
    .done_clr_i  (done_clr_i),
    .frame_end_i (frame_end),
    .commit_pt_i (commit_pt),
    .run_o       (run),
    .valid_o     (data_valid_o),
    .done_o      (frame_done_o)
  );

  assign bclk_oe_o = run & clk_dir_out_i;
  assign fs_oe_o   = run & fs_dir_out_i;

  AST_SYNC_NEEDS_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> run); // R10
endmodule

// File: tb/test_audio_frame_clk_ctrl.sv
module test_audio_frame_clk_ctrl;
  localparam int CLK_PER = 10;
  localparam int FL  = 8;
  localparam int WL  = 3;
  localparam int HP  = 1;
  localparam int BIT = 2 * HP;
  localparam int FRM = FL * BIT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, stop = 0, wide = 0, cdir = 1, fdir = 1, dclr = 0;
  logic bclk, fs, boe, foe, dv, done;

  int tests = 0, fails = 0;
  int n_fs_rise, n_fs_hi, n_valid, n_boe, n_foe, n_fall;
  logic mon_clr = 1'b0, fs_prev = 1'b0, bclk_prev = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  audio_frame_clk_ctrl #(.FRAME_LEN(FL), .WORD_LEN(WL), .HALF_PER(HP)) i_audio_frame_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .stop_clk_i(stop), .sync_wide_i(wide),
    .clk_dir_out_i(cdir), .fs_dir_out_i(fdir), .done_clr_i(dclr),
    .bclk_o(bclk), .fs_o(fs), .bclk_oe_o(boe), .fs_oe_o(foe),
    .data_valid_o(dv), .frame_done_o(done));

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (mon_clr) begin
      n_fs_rise = 0; n_fs_hi = 0; n_valid = 0; n_boe = 0; n_foe = 0; n_fall = 0;
    end else begin
      if (fs && !fs_prev) n_fs_rise++;
      if (fs) n_fs_hi++;
      if (dv) n_valid++;
      if (boe) n_boe++;
      if (foe) n_foe++;
      if (!bclk && bclk_prev) n_fall++;
    end
    fs_prev = fs;
    bclk_prev = bclk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; en = 0; stop = 0; dclr = 0; cdir = 1; fdir = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // leaves caller at the negedge just before the start edge, en already high
  task automatic arm_start(input logic with_stop);
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0; en = 1; stop = with_stop;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", "reset outputs", {bclk, fs, boe, foe, dv, done}, 0);

    // R4 / R8 / R2 / R5 sweep: disable bit position and sync width
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < FL; p++) begin
        int nf;
        do_reset();
        wide = w[0];
        arm_start(1'b1);             // stop pulse in the enable cycle (R5: set wins)
        @(negedge clk); stop = 0;    // n0
        repeat (BIT * p) @(negedge clk);
        en = 0;
        repeat (4 * FRM) @(negedge clk);
        nf = (p >= FL - 4) ? 2 : 1;
        chk(p >= FL - 4 ? "R8" : "R4", "frames", n_fs_rise, nf);
        chk("R3", "valid cycles", n_valid, FRM);
        chk("R2", "bclk falls", n_fall, FL * nf);
        chk("R2", "fs high cycles", n_fs_hi, nf * BIT * (w == 1 ? WL : 1));
        chk("R10", "bclk oe cycles", n_boe, nf * FRM);
        chk("R4", "stopped pins", {bclk, fs, boe, foe, dv}, 0);
        chk("R9", "done set", done, 1);
      end
    end

    // R6 / R7 / R10: disable without stop, clock pin as input
    do_reset();
    wide = 0; cdir = 0;
    arm_start(1'b0);
    @(negedge clk);                  // n0
    repeat (2) @(negedge clk); en = 0;   // n2
    repeat (38) @(negedge clk);          // n40
    chk("R6", "frames while disabled", n_fs_rise, 3);
    chk("R6", "valid cycles", n_valid, FRM);
    chk("R6", "fs oe cycles", n_foe, 41);
    chk("R10", "bclk oe with input dir", n_boe, 0);
    chk("R9", "done before stop", done, 0);
    stop = 1;
    @(negedge clk); stop = 0;
    repeat (30) @(negedge clk);
    chk("R7", "frames after late stop", n_fs_rise, 3);
    chk("R7", "fs oe cycles", n_foe, 3 * FRM);
    chk("R7", "bclk falls", n_fall, 3 * FL);
    chk("R9", "done after stop", done, 1);
    dclr = 1;
    @(negedge clk); dclr = 0;
    chk("R9", "done cleared", done, 0);
    repeat (10) @(negedge clk);
    chk("R9", "done stays clear", done, 0);

    // R11: re-enable clears stop request
    cdir = 1;
    arm_start(1'b0);
    @(negedge clk); en = 0;          // n0
    repeat (48) @(negedge clk);      // n48
    chk("R11", "still running", boe, 1);
    chk("R11", "frames", n_fs_rise, 4);
    chk("R11", "valid cycles", n_valid, FRM);
    stop = 1;
    @(negedge clk); stop = 0;
    repeat (30) @(negedge clk);
    chk("R11", "bclk oe cycles", n_boe, 4 * FRM);
    chk("R9", "done after second stop", done, 1);

    // R5: stop pulse two frames before disable
    do_reset();
    arm_start(1'b0);
    @(negedge clk);                  // n0
    repeat (2) @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;        // n3
    repeat (29) @(negedge clk); en = 0;  // n32
    repeat (40) @(negedge clk);
    chk("R5", "frames", n_fs_rise, 3);
    chk("R5", "valid cycles", n_valid, 3 * FRM);
    chk("R5", "fs oe cycles", n_foe, 3 * FRM);
    chk("R5", "done", done, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule